// File: doc/BRIEF.md
# System Counter with Per-Processor Mode Select

This block is the system-wide counter/timer register file of a multi-processor timer complex. A free-running counter advances by one unit on every cycle in which the tick enable is high. The counter counts toward a programmable limit. When it reaches the limit it wraps to zero, sets a sticky reached flag and raises an interrupt. Software clears the interrupt and the flag by reading the limit register. Software can reload the limit in two ways: one write also zeroes the counter and drops the interrupt, the other leaves the counter running. Counter and limit are exposed on the bus with a 512-unit granularity, so bits 8:0 always read as zero.

The block also holds a mode register with one bit per processor. A bit set to 1 places that processor's private timer in user mode, and a bit cleared to 0 places it in system mode. The stored bits drive the processor timers directly. On a mode write the block emits a one-cycle restart pulse for every processor whose bit actually changed. It also emits a one-cycle user-load pulse for every bit written as 1, which tells that processor's timer to drop its interrupt and load its user-mode maximum. The processor timers are outside this block.

The bus side is a small two-state machine. In `ST_IDLE` no read data is presented. A read request takes the transition `IDLE->RDATA` into `ST_RDATA`, where `rd_valid` is high for one cycle. A further read keeps the machine in `ST_RDATA` (`RDATA->RDATA`). Any other cycle takes the transition `RDATA->IDLE` back, and a non-read cycle in `ST_IDLE` stays there (`IDLE->IDLE`).

Top module: `sys_tmr_top`

## Requirements
- R1: After reset: `irq` is 0, `cpu_mode`, `cpu_restart` and `cpu_user_load` are 0, index 0 reads 0x7FFFFE00, and index 1 reads 0x00000000.
- R2: Each clock with `tick_en` high advances the counter by one unit, which adds 0x200 to the index 1 read value.
- R3: When the incremented counter reaches or passes the limit, the counter returns to 0, and the reached flag (index 1 bit 31) and `irq` are set on that same edge.
- R4: A read of index 0 returns the limit (bit 31 zero, bits 8:0 zero). It also clears `irq` and the reached flag, unless a wrap occurs on the same edge.
- R5: A write to index 0 stores `wdata & 0x7FFFFE00` as the limit, with 0 replaced by 0x7FFFFE00. It also zeroes the counter and clears `irq`, and it takes priority over a tick on the same edge.
- R6: A write to index 2 loads the limit with the same masking and zero rule. It leaves the counter, the reached flag and `irq` unchanged.
- R7: A read of index 1 returns {reached, counter[30:9], 9'b0}. The read has no side effect.
- R8: A write to index 4 stores `wdata[NCPU-1:0]` as the mode. Bit i = 1 selects user mode for processor i. A read of index 4 returns the mode zero-extended, and `cpu_mode` shows it from the edge of the write.
- R9: On a mode write, `cpu_restart` is high for exactly one clock, and only for the bits whose value changed.
- R10: On a mode write, `cpu_user_load` is high for exactly one clock for every bit written as 1, whether or not that bit changed.
- R11: Indices 3, 5, 6 and 7 read as zero. Writes to them change no register.
- R12: Read data and `rd_valid` appear on the clock edge after the one that samples the read request. `rd_valid` stays low after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 3 | Register index (word address) |
| req_wdata | input | 32 | Write data |
| tick_en | input | 1 | Counter advance enable |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq | output | 1 | System counter interrupt |
| cpu_mode | output | NCPU | Per-processor mode, 1 = user |
| cpu_restart | output | NCPU | One-clock restart pulse per changed bit |
| cpu_user_load | output | NCPU | One-clock user-load pulse per bit written 1 |

## Verification
Every result of this block is due exactly one edge after the stimulus that causes it: the counter, the wrap flags and `irq` after the tick edge, the limit and mode after the write edge, and the read data after the read edge. The driver applies each request at a falling edge and holds it across a single rising edge. Register-level results are checked at the following falling edge. Read results are pushed into an expected queue when the read is issued, and they are popped by a monitor on the falling edge where `rd_valid` is high. A result therefore cannot match one cycle early or late.

// File: rtl/sys_tmr_pkg.sv
package sys_tmr_pkg;

    localparam int DATA_W   = 32;
    localparam int UNIT_LSB = 9;                       // counter granularity: 512
    localparam int CNT_W    = DATA_W - 1 - UNIT_LSB;   // bits 30:9

    typedef enum logic [2:0] {
        IDX_LIM_CLR  = 3'd0,
        IDX_COUNT    = 3'd1,
        IDX_LIM_KEEP = 3'd2,
        IDX_NONE     = 3'd3,
        IDX_MODE     = 3'd4
    } reg_idx_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_RDATA = 1'b1
    } bus_state_e;

endpackage

// File: rtl/sys_tmr_count.sv
module sys_tmr_count #(
    parameter int CW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ld_clear,
    input  logic          ld_keep,
    input  logic [CW-1:0] ld_val,
    input  logic          rd_clear,
    output logic [CW-1:0] lim,
    output logic [CW-1:0] cnt,
    output logic          reached,
    output logic          irq
);
    localparam logic [CW-1:0] LIM_TOP = '1;

    logic [CW-1:0] lim_q, cnt_q;
    logic          reached_q, irq_q;
    logic [CW:0]   cnt_inc;
    logic [CW-1:0] lim_fix;
    logic          wrap;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        wrap    = tick && (cnt_inc >= {1'b0, lim_q});
        lim_fix = (ld_val == '0) ? LIM_TOP : ld_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q     <= LIM_TOP;
            cnt_q     <= '0;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (ld_clear || ld_keep) lim_q <= lim_fix;
            if (ld_clear) begin
                cnt_q <= '0;
                irq_q <= 1'b0;
            end else if (wrap) begin
                cnt_q     <= '0;
                reached_q <= 1'b1;
                irq_q     <= 1'b1;
            end else begin
                if (tick) cnt_q <= cnt_inc[CW-1:0];
                if (rd_clear) begin
                    irq_q     <= 1'b0;
                    reached_q <= 1'b0;
                end
            end
        end
    end

    assign lim     = lim_q;
    assign cnt     = cnt_q;
    assign reached = reached_q;
    assign irq     = irq_q;
endmodule

// File: rtl/sys_tmr_modectl.sv
module sys_tmr_modectl #(
    parameter int NCPU = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [NCPU-1:0] wval,
    output logic [NCPU-1:0] mode,
    output logic [NCPU-1:0] restart,
    output logic [NCPU-1:0] user_load
);
    logic [NCPU-1:0] mode_q, restart_q, load_q;

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[i]    <= 1'b0;
                restart_q[i] <= 1'b0;
                load_q[i]    <= 1'b0;
            end else begin
                restart_q[i] <= wr && (wval[i] != mode_q[i]);
                load_q[i]    <= wr && wval[i];
                if (wr) mode_q[i] <= wval[i];
            end
        end
    end

    assign mode      = mode_q;
    assign restart   = restart_q;
    assign user_load = load_q;
endmodule

// File: rtl/sys_tmr_top.sv
module sys_tmr_top
    import sys_tmr_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [2:0]        req_index,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              tick_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic [NCPU-1:0]   cpu_mode,
    output logic [NCPU-1:0]   cpu_restart,
    output logic [NCPU-1:0]   cpu_user_load
);
    localparam int PAD_W = DATA_W - NCPU;

    bus_state_e    state_q, state_d;
    logic          is_rd, is_wr;
    logic          wr_lim_clr, wr_lim_keep, wr_mode, rd_lim;
    logic [CNT_W-1:0] lim, cnt;
    logic          reached;
    logic [DATA_W-1:0] rd_mux, rd_q;

    always_comb begin
        is_rd       = req_valid && !req_write;
        is_wr       = req_valid &&  req_write;
        wr_lim_clr  = is_wr && (req_index == IDX_LIM_CLR);
        wr_lim_keep = is_wr && (req_index == IDX_LIM_KEEP);
        wr_mode     = is_wr && (req_index == IDX_MODE);
        rd_lim      = is_rd && (req_index == IDX_LIM_CLR);
    end

    sys_tmr_count #(.CW(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .ld_clear (wr_lim_clr),
        .ld_keep  (wr_lim_keep),
        .ld_val   (req_wdata[DATA_W-2:UNIT_LSB]),
        .rd_clear (rd_lim),
        .lim      (lim),
        .cnt      (cnt),
        .reached  (reached),
        .irq      (irq)
    );

    sys_tmr_modectl #(.NCPU(NCPU)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_mode),
        .wval      (req_wdata[NCPU-1:0]),
        .mode      (cpu_mode),
        .restart   (cpu_restart),
        .user_load (cpu_user_load)
    );

    // read multiplexer
    always_comb begin
        rd_mux = '0;
        unique case (req_index)
            IDX_LIM_CLR: rd_mux = {1'b0, lim, {UNIT_LSB{1'b0}}};
            IDX_COUNT:   rd_mux = {reached, cnt, {UNIT_LSB{1'b0}}};
            IDX_MODE:    rd_mux = {{PAD_W{1'b0}}, cpu_mode};
            default:     rd_mux = '0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = is_rd ? ST_RDATA : ST_IDLE;
            ST_RDATA: state_d = is_rd ? ST_RDATA : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (is_rd) rd_q <= rd_mux;
    end

    assign rd_valid = (state_q == ST_RDATA);
    assign rd_data  = rd_q;
endmodule

// File: rtl/sys_tmr_chk.sv
module sys_tmr_chk #(
    parameter int NCPU = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_write,
    input logic [2:0]      req_index,
    input logic            tick_en,
    input logic            rd_valid,
    input logic            irq,
    input logic [NCPU-1:0] cpu_mode,
    input logic [NCPU-1:0] cpu_restart
);
    // R3: interrupt only rises on a tick edge
    p_wrap_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick_en));

    // R4: limit read without a tick clears the interrupt
    p_read_clears_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_index == 3'd0 && !tick_en) |=> !irq);

    // R5: limit write with reset always drops the interrupt
    p_limit_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_index == 3'd0) |=> !irq);

    // R9: restart pulses mark exactly the bits that changed
    p_restart_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_restart == (cpu_mode ^ $past(cpu_mode)));

    // R11: mode moves only on a mode write
    p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && req_index == 3'd4) |=> $stable(cpu_mode));

    // R12: read data valid follows every read by one edge
    p_read_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    p_no_spurious_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);
endmodule

bind sys_tmr_top sys_tmr_chk #(.NCPU(NCPU)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_index   (req_index),
    .tick_en     (tick_en),
    .rd_valid    (rd_valid),
    .irq         (irq),
    .cpu_mode    (cpu_mode),
    .cpu_restart (cpu_restart)
);

// File: tb/sys_tmr_top_bench.sv
`timescale 1ns/1ps
module sys_tmr_top_bench;
    localparam int NCPU = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [2:0]      req_index = '0;
    logic [31:0]     req_wdata = '0;
    logic            tick_en = 1'b0;
    logic            rd_valid;
    logic [31:0]     rd_data;
    logic            irq;
    logic [NCPU-1:0] cpu_mode, cpu_restart, cpu_user_load;

    int total = 0;
    int fails = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    sys_tmr_top #(.NCPU(NCPU)) u_sys_tmr_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_index(req_index), .req_wdata(req_wdata), .tick_en(tick_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq), .cpu_mode(cpu_mode),
        .cpu_restart(cpu_restart), .cpu_user_load(cpu_user_load)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // monitor: pops expected read data when the design presents it
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                total++; fails++;
                $display("FAIL R12: actual=%h expected=none (unexpected rd_valid)", rd_data);
            end else begin
                chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic rd(input logic [2:0] idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_index = idx;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] val);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_index = idx; req_wdata = val;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; fails++;
        $display("FAIL R12: actual=hung expected=finished (watchdog)");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 mode", {28'd0, cpu_mode}, 32'd0);
        chk("R1 restart", {28'd0, cpu_restart}, 32'd0);
        chk("R1 user_load", {28'd0, cpu_user_load}, 32'd0);
        chk("R12 no valid at idle", {31'd0, rd_valid}, 32'd0);
        rd(3'd0, 32'h7FFFFE00, "R1 limit after reset");
        rd(3'd1, 32'h00000000, "R1 count after reset");

        // R2/R7 counting with limit 5 units
        wr(3'd0, 32'h00000A00);
        chk("R12 no valid after write", {31'd0, rd_valid}, 32'd0);
        ticks(3);
        rd(3'd1, 32'h00000600, "R2 R7 count after 3 ticks");
        chk("R3 no irq before limit", {31'd0, irq}, 32'd0);

        // R3 wrap
        ticks(2);
        chk("R3 irq on wrap", {31'd0, irq}, 32'd1);
        rd(3'd1, 32'h80000000, "R3 R7 reached set, count wrapped");
        chk("R7 count read keeps irq", {31'd0, irq}, 32'd1);
        rd(3'd0, 32'h00000A00, "R4 limit read value");
        chk("R4 irq cleared by limit read", {31'd0, irq}, 32'd0);
        rd(3'd1, 32'h00000000, "R4 reached cleared");

        // R5 write-with-reset
        wr(3'd0, 32'h00000400);
        ticks(2);
        chk("R5 setup irq", {31'd0, irq}, 32'd1);
        ticks(1);
        wr(3'd0, 32'h00000400);
        chk("R5 irq cleared by limit write", {31'd0, irq}, 32'd0);
        rd(3'd1, 32'h80000000, "R5 counter zeroed");
        wr(3'd0, 32'h12345FFF);
        rd(3'd0, 32'h12345E00, "R5 limit masked");
        wr(3'd0, 32'h000001FF);
        rd(3'd0, 32'h7FFFFE00, "R5 zero limit replaced");

        // R6 write-without-reset
        wr(3'd0, 32'h00000A00);
        rd(3'd0, 32'h00000A00, "R4 clear reached before R6");
        ticks(3);
        wr(3'd2, 32'h00000E00);
        rd(3'd1, 32'h00000600, "R6 count kept");
        ticks(3);
        chk("R6 no wrap at old limit", {31'd0, irq}, 32'd0);
        ticks(1);
        chk("R6 wrap at new limit", {31'd0, irq}, 32'd1);
        wr(3'd2, 32'h00001000);
        chk("R6 irq kept", {31'd0, irq}, 32'd1);
        rd(3'd0, 32'h00001000, "R6 limit loaded");
        wr(3'd2, 32'h80000000);
        rd(3'd0, 32'h7FFFFE00, "R6 zero limit replaced");
        wr(3'd2, 32'h00001000);

        // R8 R9 R10 mode register
        wr(3'd4, 32'hFFFFFFF5);
        chk("R8 mode masked", {28'd0, cpu_mode}, 32'h5);
        chk("R9 restart on changed bits", {28'd0, cpu_restart}, 32'h5);
        chk("R10 user_load on ones", {28'd0, cpu_user_load}, 32'h5);
        @(negedge clk);
        chk("R9 restart one clock", {28'd0, cpu_restart}, 32'h0);
        chk("R10 user_load one clock", {28'd0, cpu_user_load}, 32'h0);
        rd(3'd4, 32'h00000005, "R8 mode read");
        wr(3'd4, 32'h00000003);
        chk("R9 restart only changed", {28'd0, cpu_restart}, 32'h6);
        chk("R10 user_load all ones", {28'd0, cpu_user_load}, 32'h3);
        wr(3'd4, 32'h00000003);
        chk("R9 no restart when same", {28'd0, cpu_restart}, 32'h0);
        chk("R10 user_load repeated", {28'd0, cpu_user_load}, 32'h3);

        // R11 unimplemented indices
        for (int i = 5; i < 8; i++) wr(3'(i), 32'hFFFFFFFF);
        wr(3'd3, 32'hFFFFFFFF);
        chk("R11 mode untouched", {28'd0, cpu_mode}, 32'h3);
        chk("R11 no restart", {28'd0, cpu_restart}, 32'h0);
        rd(3'd0, 32'h00001000, "R11 limit untouched");
        rd(3'd3, 32'h0, "R11 index 3 reads zero");
        for (int i = 5; i < 8; i++) rd(3'(i), 32'h0, "R11 high index reads zero");

        repeat (3) @(negedge clk);
        chk("R12 all reads answered", exp_q.size(), 32'd0);
        summary();
        $finish;
    end
endmodule